// File: doc/BRIEF.md
# Node Physical Address Router

This block takes a 64-bit address that falls in the physical-access window of a multi-node shared-memory machine and turns it into a routing decision. It checks the window and reserved fields and classifies the access as cached or uncached. For uncached accesses it also picks one of four special spaces. It then splits the 40-bit physical part into a node number and an in-node offset, and applies local-node aliasing so that low addresses reach the node that issued them.

Two node-numbering modes are supported. The narrow mode has 256 nodes with 4 GB each. The wide mode has 512 nodes with 2 GB each. The mode is chosen by a select input that is captured only while the router is idle, so a mode change never splits a request. The second CPU of a node sees the first two 64 KB blocks of the node-special space exchanged. The result is registered and presented one clock after the request strobe.

Top module: `pa_node_router`

## Requirements
- R1: An address is illegal when bits 63:62 are not 10, when the algorithm field (bits 61:59) is 000 or 001, when any of bits 56:40 is set, or when the qualifier field (bits 58:57) is nonzero with an algorithm other than 010 or 111.
- R2: For an illegal address the response has `rsp_illegal`=1 while `tgt_node`, `tgt_offset`, `rsp_cached` and `rsp_space` are all 0.
- R3: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, and the result outputs keep their value until the next request is decoded.
- R4: Algorithms 011, 100, 101 and 110 give `rsp_cached`=1 and `rsp_space`=0. Algorithms 010 and 111 give `rsp_cached`=0.
- R5: For an uncached access the qualifier field sets `rsp_space`: 00 gives 1 (node-special), 01 gives 2 (I/O), 10 gives 3 (synchronization) and 11 gives 4 (uncached memory).
- R6: In narrow mode (`mode_sel`=0) the node is address bits 39:32, zero-extended to 9 bits, and the offset is bits 31:0.
- R7: In wide mode (`mode_sel`=1) the node is address bits 39:31 and the offset is bits 30:0 with bit 31 cleared.
- R8: A cached access with bits 39:0 below 0x0400_0000 targets the local node. In narrow mode that is the low 8 bits of `local_node`. At 0x0400_0000 and above, the address field is used.
- R9: A node-special access with bits 39:0 below 0x3000_0000 targets the local node. At or above that limit, the address field is used.
- R10: I/O, synchronization and uncached-memory accesses take the node from the address with no aliasing.
- R11: In node-special space with `cpu_id`=1, an in-node offset below 0x20000 has bit 16 inverted. Offsets at or above 0x20000, CPU 0, and every other space are not remapped.
- R12: `mode_sel` is captured only on clock edges where neither `req_valid` nor `rsp_valid` is high. Its reset value is narrow mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per address |
| req_addr | input | 64 | Address to decode |
| local_node | input | 9 | Node number of the issuing node |
| cpu_id | input | 1 | Index of the issuing CPU within its node |
| mode_sel | input | 1 | Node-numbering mode: 0 narrow, 1 wide |
| rsp_valid | output | 1 | Decoded result present |
| tgt_node | output | 9 | Target node number |
| tgt_offset | output | 32 | Offset within the target node |
| rsp_cached | output | 1 | Access uses a cached algorithm |
| rsp_space | output | 3 | Space code (0 cached, 1 special, 2 I/O, 3 sync, 4 uncached memory) |
| rsp_illegal | output | 1 | Address violates the window or reserved-field rules |

## Verification
The hardest case to reach from the ports is a change of `mode_sel` while a request is in flight, because the captured mode is internal state. The bench moves `mode_sel` in the same cycle as a request strobe and restores it before the router goes idle. It then sends a second request, and the node/offset split of both responses shows which mode was applied. The aliasing limits are hit at exactly one address below and at each threshold. The block exchange is checked on both sides of 0x20000, for both CPUs, and with an explicit remote node.

// File: rtl/pa_router_pkg.sv
package pa_router_pkg;

   typedef enum logic [2:0] {
      SP_CACHED  = 3'd0,
      SP_SPECIAL = 3'd1,
      SP_IO      = 3'd2,
      SP_SYNC    = 3'd3,
      SP_UMEM    = 3'd4
   } pa_space_e;

   localparam logic [2:0] ALG_UNCACHED = 3'b010;
   localparam logic [2:0] ALG_UNC_ACCEL = 3'b111;
   localparam logic [1:0] WINDOW_TAG = 2'b10;

endpackage

// File: rtl/pa_field_check.sv
module pa_field_check
   import pa_router_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int PA_W   = 40
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              legal,
   output logic              cached,
   output pa_space_e         space
);
   localparam int ALG_LSB  = ADDR_W - 5;
   localparam int QUAL_LSB = ALG_LSB - 2;
   localparam int MBZ_W    = QUAL_LSB - PA_W;

   if (MBZ_W < 1) begin : g_bad_width
      $error("pa_field_check: ADDR_W too small for PA_W");
   end

   logic [1:0]       tag;
   logic [2:0]       alg;
   logic [1:0]       qual;
   logic [MBZ_W-1:0] mbz;
   logic             unc;

   assign tag  = addr[ADDR_W-1 -: 2];
   assign alg  = addr[ALG_LSB +: 3];
   assign qual = addr[QUAL_LSB +: 2];
   assign mbz  = addr[PA_W +: MBZ_W];
   assign unc  = (alg == ALG_UNCACHED) || (alg == ALG_UNC_ACCEL);

   always_comb begin
      legal  = (tag == WINDOW_TAG) && (alg[2:1] != 2'b00) && (mbz == '0)
               && (unc || (qual == 2'b00));
      cached = legal && !unc;
      space  = SP_CACHED;
      if (legal && unc) begin
         unique case (qual)
            2'b00:   space = SP_SPECIAL;
            2'b01:   space = SP_IO;
            2'b10:   space = SP_SYNC;
            default: space = SP_UMEM;
         endcase
      end
   end

   always_comb begin
      assert_cached_class_R4: assert (!cached || (space == SP_CACHED))
         else $error("cached access classed as uncached space");
   end

endmodule

// File: rtl/pa_node_split.sv
module pa_node_split #(
   parameter int PA_W   = 40,
   parameter int OFF_W  = 32,
   parameter int NODE_W = 9
) (
   input  logic [PA_W-1:0]   pa,
   input  logic              mode_wide,
   output logic [NODE_W-1:0] node_raw,
   output logic [OFF_W-1:0]  off_raw
);
   localparam int NODE_W_N = PA_W - OFF_W;
   localparam int PAD_W    = NODE_W - NODE_W_N;

   if (PAD_W != 1) begin : g_bad_split
      $error("pa_node_split: wide mode must add exactly one node bit");
   end

   logic [NODE_W-1:0] node_n;
   logic [NODE_W-1:0] node_w;
   logic [OFF_W-1:0]  off_n;
   logic [OFF_W-1:0]  off_w;

   assign node_n = {{PAD_W{1'b0}}, pa[PA_W-1:OFF_W]};
   assign off_n  = pa[OFF_W-1:0];
   assign node_w = pa[PA_W-1:OFF_W-1];
   assign off_w  = {1'b0, pa[OFF_W-2:0]};

   assign node_raw = mode_wide ? node_w : node_n;
   assign off_raw  = mode_wide ? off_w  : off_n;

endmodule

// File: rtl/pa_local_alias.sv
module pa_local_alias
   import pa_router_pkg::*;
#(
   parameter int              PA_W          = 40,
   parameter int              OFF_W         = 32,
   parameter int              NODE_W        = 9,
   parameter int              CACHED_LIM_LG = 26,
   parameter logic [PA_W-1:0] SPECIAL_LIM   = 40'h00_3000_0000,
   parameter int              SWAP_BLK_LG   = 16,
   parameter bit              SWAP_EN       = 1'b1
) (
   input  logic [PA_W-1:0]   pa,
   input  pa_space_e         space,
   input  logic              legal,
   input  logic              mode_wide,
   input  logic [NODE_W-1:0] local_node,
   input  logic              cpu_id,
   input  logic [NODE_W-1:0] node_raw,
   input  logic [OFF_W-1:0]  off_raw,
   output logic [NODE_W-1:0] node_out,
   output logic [OFF_W-1:0]  off_out
);
   localparam int              NODE_W_N   = PA_W - OFF_W;
   localparam logic [PA_W-1:0] CACHED_LIM = PA_W'(1) << CACHED_LIM_LG;
   localparam logic [NODE_W-1:0] NARROW_MASK =
      {{(NODE_W-NODE_W_N){1'b0}}, {NODE_W_N{1'b1}}};

   if (SWAP_BLK_LG + 1 >= OFF_W) begin : g_bad_swap
      $error("pa_local_alias: swap window exceeds offset width");
   end

   logic [NODE_W-1:0] local_eff;
   logic              cached_low;
   logic              special_low;

   assign local_eff   = mode_wide ? local_node : (local_node & NARROW_MASK);
   assign cached_low  = legal && (space == SP_CACHED) && (pa < CACHED_LIM);
   assign special_low = legal && (space == SP_SPECIAL) && (pa < SPECIAL_LIM);

   always_comb begin
      node_out = node_raw;
      if (cached_low) begin
         node_out = node_raw | local_eff;
      end else if (special_low) begin
         node_out = local_eff;
      end
   end

   if (SWAP_EN) begin : g_swap
      localparam logic [OFF_W-1:0] SWAP_BIT = OFF_W'(1) << SWAP_BLK_LG;
      logic in_window;
      assign in_window = ((off_raw >> (SWAP_BLK_LG + 1)) == '0);
      assign off_out = (legal && (space == SP_SPECIAL) && cpu_id && in_window)
                       ? (off_raw ^ SWAP_BIT) : off_raw;
   end else begin : g_no_swap
      assign off_out = off_raw;
   end

   always_comb begin
      assert_swap_scope_R11: assert ((off_out == off_raw) ||
                                     ((space == SP_SPECIAL) && cpu_id))
         else $error("offset remapped outside special space of CPU 1");
   end

endmodule

// File: rtl/pa_node_router.sv
module pa_node_router
   import pa_router_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int PA_W   = 40,
   parameter int OFF_W  = 32,
   parameter int NODE_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [63:0]       req_addr,
   input  logic [8:0]        local_node,
   input  logic              cpu_id,
   input  logic              mode_sel,
   output logic              rsp_valid,
   output logic [8:0]        tgt_node,
   output logic [31:0]       tgt_offset,
   output logic              rsp_cached,
   output logic [2:0]        rsp_space,
   output logic              rsp_illegal
);
   localparam int NODE_W_N = PA_W - OFF_W;

   if (ADDR_W != 64 || NODE_W != 9 || OFF_W != 32) begin : g_bad_ports
      $error("pa_node_router: parameters disagree with port widths");
   end

   logic              mode_q;
   logic              legal;
   logic              cached;
   pa_space_e         space;
   logic [NODE_W-1:0] node_raw;
   logic [OFF_W-1:0]  off_raw;
   logic [NODE_W-1:0] node_al;
   logic [OFF_W-1:0]  off_al;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
      end else if (!req_valid && !rsp_valid) begin
         mode_q <= mode_sel;
      end
   end

   pa_field_check #(.ADDR_W(ADDR_W), .PA_W(PA_W)) u_check (
      .addr   (req_addr),
      .legal  (legal),
      .cached (cached),
      .space  (space)
   );

   pa_node_split #(.PA_W(PA_W), .OFF_W(OFF_W), .NODE_W(NODE_W)) u_split (
      .pa        (req_addr[PA_W-1:0]),
      .mode_wide (mode_q),
      .node_raw  (node_raw),
      .off_raw   (off_raw)
   );

   pa_local_alias #(.PA_W(PA_W), .OFF_W(OFF_W), .NODE_W(NODE_W)) u_alias (
      .pa         (req_addr[PA_W-1:0]),
      .space      (space),
      .legal      (legal),
      .mode_wide  (mode_q),
      .local_node (local_node),
      .cpu_id     (cpu_id),
      .node_raw   (node_raw),
      .off_raw    (off_raw),
      .node_out   (node_al),
      .off_out    (off_al)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         tgt_node    <= '0;
         tgt_offset  <= '0;
         rsp_cached  <= 1'b0;
         rsp_space   <= 3'd0;
         rsp_illegal <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_illegal <= !legal;
            tgt_node    <= legal ? node_al : '0;
            tgt_offset  <= legal ? off_al  : '0;
            rsp_cached  <= cached;
            rsp_space   <= legal ? 3'(space) : 3'd0;
         end
      end
   end

   assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid) else $error("response missing");

   assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid) else $error("response without request");

   assert_illegal_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_illegal) |->
         (tgt_node == '0 && tgt_offset == '0 && !rsp_cached && rsp_space == 3'd0))
      else $error("illegal response carries data");

   assert_cached_space_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_cached) |-> (rsp_space == 3'd0 && !rsp_illegal))
      else $error("cached flag with uncached space");

   assert_mode_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid || rsp_valid) |=> (mode_q == $past(mode_q)))
      else $error("mode changed while busy");

   assert_cached_alias_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_cached && $past(req_addr[PA_W-1:26]) == '0) |->
         (tgt_node == ($past(mode_q) ? $past(local_node)
                      : {{(NODE_W-NODE_W_N){1'b0}}, $past(local_node[NODE_W_N-1:0])})))
      else $error("low cached address not sent to local node");

   assert_explicit_node_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_illegal && rsp_space >= 3'd2) |->
         (tgt_node == $past(node_raw)))
      else $error("aliasing applied to explicit-node space");

endmodule

// File: tb/tb_pa_node_router.sv
module tb_pa_node_router;
   localparam int CLK_P = 10;
   localparam int WDOG  = 5000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic [63:0] req_addr;
   logic [8:0]  local_node;
   logic        cpu_id;
   logic        mode_sel;
   logic        rsp_valid;
   logic [8:0]  tgt_node;
   logic [31:0] tgt_offset;
   logic        rsp_cached;
   logic [2:0]  rsp_space;
   logic        rsp_illegal;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   pa_node_router dut (
      .clk, .rst_n, .req_valid, .req_addr, .local_node, .cpu_id, .mode_sel,
      .rsp_valid, .tgt_node, .tgt_offset, .rsp_cached, .rsp_space, .rsp_illegal
   );

   function automatic logic [63:0] mk(input logic [2:0] alg, input logic [1:0] q,
                                      input logic [39:0] pa);
      return {2'b10, alg, q, 17'd0, pa};
   endfunction

   task automatic expect_rsp(input string req, input logic [8:0] en,
                             input logic [31:0] eo, input logic ec,
                             input logic [2:0] es, input logic ei);
      n_chk++;
      if (rsp_valid !== 1'b1 || tgt_node !== en || tgt_offset !== eo ||
          rsp_cached !== ec || rsp_space !== es || rsp_illegal !== ei) begin
         n_bad++;
         $display("FAIL %s: got v=%b node=%h off=%h c=%b sp=%0d ill=%b, exp v=1 node=%h off=%h c=%b sp=%0d ill=%b",
                  req, rsp_valid, tgt_node, tgt_offset, rsp_cached, rsp_space,
                  rsp_illegal, en, eo, ec, es, ei);
      end
   endtask

   task automatic send(input logic [63:0] a, input logic cpu);
      @(negedge clk);
      req_addr  = a;
      cpu_id    = cpu;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic set_mode(input logic m);
      @(negedge clk);
      mode_sel = m;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset;
      n_chk++;
      if (rsp_valid !== 0 || tgt_node !== 0 || tgt_offset !== 0 ||
          rsp_cached !== 0 || rsp_space !== 0 || rsp_illegal !== 0) begin
         n_bad++;
         $display("FAIL R3 reset: got v=%b node=%h off=%h, exp all zero",
                  rsp_valid, tgt_node, tgt_offset);
      end
   endtask

   task automatic t_narrow_cached;
      send(mk(3'b110, 2'b00, 40'h12_3456_789A), 1'b0);
      expect_rsp("R4 R6 narrow cached split", 9'h012, 32'h3456_789A, 1, 0, 0);
      send(mk(3'b011, 2'b00, 40'h00_0100_0000), 1'b0);
      expect_rsp("R8 cached below 64MB", 9'h0A5, 32'h0100_0000, 1, 0, 0);
      send(mk(3'b100, 2'b00, 40'h00_03FF_FFFF), 1'b0);
      expect_rsp("R8 cached last aliased", 9'h0A5, 32'h03FF_FFFF, 1, 0, 0);
      send(mk(3'b101, 2'b00, 40'h00_0400_0000), 1'b0);
      expect_rsp("R8 cached at 64MB", 9'h000, 32'h0400_0000, 1, 0, 0);
   endtask

   task automatic t_uncached_spaces;
      send(mk(3'b010, 2'b01, 40'h07_0000_1000), 1'b0);
      expect_rsp("R5 R10 io space", 9'h007, 32'h0000_1000, 0, 2, 0);
      send(mk(3'b111, 2'b10, 40'h00_0000_0000), 1'b1);
      expect_rsp("R5 R10 R11 sync no alias", 9'h000, 32'h0000_0000, 0, 3, 0);
      send(mk(3'b010, 2'b11, 40'h00_0000_0100), 1'b1);
      expect_rsp("R5 R10 R11 umem no alias", 9'h000, 32'h0000_0100, 0, 4, 0);
   endtask

   task automatic t_special_alias;
      send(mk(3'b010, 2'b00, 40'h00_2FFF_FFFF), 1'b0);
      expect_rsp("R9 special below limit", 9'h0A5, 32'h2FFF_FFFF, 0, 1, 0);
      send(mk(3'b010, 2'b00, 40'h00_3000_0000), 1'b0);
      expect_rsp("R9 special at limit", 9'h000, 32'h3000_0000, 0, 1, 0);
      send(mk(3'b111, 2'b00, 40'h05_0000_8000), 1'b0);
      expect_rsp("R9 special explicit node", 9'h005, 32'h0000_8000, 0, 1, 0);
   endtask

   task automatic t_block_swap;
      send(mk(3'b010, 2'b00, 40'h00_0000_0000), 1'b1);
      expect_rsp("R11 cpu1 block0", 9'h0A5, 32'h0001_0000, 0, 1, 0);
      send(mk(3'b010, 2'b00, 40'h00_0001_0004), 1'b1);
      expect_rsp("R11 cpu1 block1", 9'h0A5, 32'h0000_0004, 0, 1, 0);
      send(mk(3'b010, 2'b00, 40'h00_0002_0000), 1'b1);
      expect_rsp("R11 cpu1 above window", 9'h0A5, 32'h0002_0000, 0, 1, 0);
      send(mk(3'b010, 2'b00, 40'h00_0000_0000), 1'b0);
      expect_rsp("R11 cpu0 unchanged", 9'h0A5, 32'h0000_0000, 0, 1, 0);
      send(mk(3'b010, 2'b00, 40'h05_0000_0000), 1'b1);
      expect_rsp("R11 cpu1 remote node", 9'h005, 32'h0001_0000, 0, 1, 0);
      send(mk(3'b110, 2'b00, 40'h00_0001_0000), 1'b1);
      expect_rsp("R11 cached not swapped", 9'h0A5, 32'h0001_0000, 1, 0, 0);
   endtask

   task automatic t_illegal;
      send({2'b11, 62'h0}, 1'b0);
      expect_rsp("R1 R2 wrong window", 9'h0, 32'h0, 0, 0, 1);
      send(mk(3'b000, 2'b00, 40'h00_0000_1000), 1'b0);
      expect_rsp("R1 R2 alg 000", 9'h0, 32'h0, 0, 0, 1);
      send(mk(3'b001, 2'b11, 40'h00_0000_1000), 1'b0);
      expect_rsp("R1 R2 alg 001", 9'h0, 32'h0, 0, 0, 1);
      send(mk(3'b110, 2'b00, 40'h00_0000_1000) | 64'h0000_2000_0000_0000, 1'b0);
      expect_rsp("R1 R2 reserved bit 45", 9'h0, 32'h0, 0, 0, 1);
      send(mk(3'b110, 2'b01, 40'h00_0000_1000), 1'b0);
      expect_rsp("R1 R2 cached with qualifier", 9'h0, 32'h0, 0, 0, 1);
   endtask

   task automatic t_wide_mode;
      set_mode(1'b1);
      send(mk(3'b110, 2'b00, 40'h12_B456_789A), 1'b0);
      expect_rsp("R7 wide split", 9'h025, 32'h3456_789A, 1, 0, 0);
      send(mk(3'b110, 2'b00, 40'h00_0000_0100), 1'b0);
      expect_rsp("R7 R8 wide cached alias", 9'h1A5, 32'h0000_0100, 1, 0, 0);
      send(mk(3'b010, 2'b01, 40'hFF_8000_0000), 1'b0);
      expect_rsp("R7 R10 wide top node", 9'h1FF, 32'h0000_0000, 0, 2, 0);
   endtask

   task automatic t_mode_hold;
      @(negedge clk);
      req_addr  = mk(3'b110, 2'b00, 40'h12_B456_789A);
      cpu_id    = 1'b0;
      req_valid = 1'b1;
      mode_sel  = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      mode_sel  = 1'b1;
      expect_rsp("R12 mode held during request", 9'h025, 32'h3456_789A, 1, 0, 0);
      @(negedge clk);
      n_chk++;
      if (rsp_valid !== 1'b0 || tgt_node !== 9'h025) begin
         n_bad++;
         $display("FAIL R3 hold after response: got v=%b node=%h, exp v=0 node=025",
                  rsp_valid, tgt_node);
      end
      send(mk(3'b110, 2'b00, 40'h12_B456_789A), 1'b0);
      expect_rsp("R12 mode still wide", 9'h025, 32'h3456_789A, 1, 0, 0);
      set_mode(1'b0);
      send(mk(3'b110, 2'b00, 40'h12_B456_789A), 1'b0);
      expect_rsp("R6 R12 back to narrow", 9'h012, 32'hB456_789A, 1, 0, 0);
   endtask

   initial begin
      rst_n      = 1'b0;
      req_valid  = 1'b0;
      req_addr   = '0;
      local_node = 9'h1A5;
      cpu_id     = 1'b0;
      mode_sel   = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_narrow_cached();
      t_uncached_spaces();
      t_special_alias();
      t_block_swap();
      t_illegal();
      t_wide_mode();
      t_mode_hold();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (WDOG) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout, exp completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule